// File: doc/BRIEF.md
# Vector even/odd deinterleave unit

This block executes the single-source unzip operations of a vector unit. The source register group holds twice as many registers as the destination group. The block gathers either the even-indexed or the odd-indexed elements of the source group and packs them densely into the destination group. Destination element i receives source element 2i for the even variant and source element 2i+1 for the odd variant.

The pipeline supplies the decoded instruction fields and the current vector type state, which is element width, grouping, tail and mask policy, vl and vstart. It also supplies the mask register, the full source group and the old contents of the destination group. One cycle later the block returns a done pulse, the merged destination data and a per-register write enable. On an illegal encoding or an illegal configuration it returns an illegal flag instead of a write. When an operation retires legally, a strobe tells the pipeline to clear vstart.

The destination bus covers four registers and the source bus covers eight. Register n of a group sits at bus bits [n*VLEN +: VLEN], and element i of a group sits at bits [i*SEW +: SEW].

Top module: `vdeint_unit`

## Requirements
- R1: For the even selector, every active body element i of the destination equals source element 2i.
- R2: For the odd selector, every active body element i of the destination equals source element 2i+1.
- R3: An operation decodes only with funct6 = 010010 and funct3 = 010, and with the vs1 selector field equal to 01011 (even) or 01111 (odd). Any other value of these fields gives illegal_o = 1 and no write.
- R4: The operation is illegal for each of the following values. lmul_i encodes the destination grouping as 000 = 1, 001 = 2, 010 = 4, 011 = 8, 101 = 1/8, 110 = 1/4 and 111 = 1/2, with 100 reserved. A destination grouping of 8 is illegal. The reserved grouping code is illegal. An element-width code sew_i above the configured maximum is illegal, where 0 = 8 bits, 1 = 16 bits and 2 = 32 bits. An element width larger than ELEN times a fractional grouping is illegal.
- R5: Register rules make the operation illegal in these cases. vd_idx_i is not a multiple of the destination register count. vs2_idx_i is not a multiple of the source register count, which is twice the destination count and at least 1. The two groups overlap while vd_idx_i differs from vs2_idx_i. The operation is masked while vd_idx_i is 0.
- R6: A vl above VLMAX of the destination (VLEN times grouping divided by element width) is illegal.
- R7: With vm_i = 0, body element i is active only when mask bit i is 1. An inactive body element keeps its old value when vma_i = 0 and becomes all ones when vma_i = 1.
- R8: A group element at index vl or above is a tail element. It keeps its old value when vta_i = 0 and becomes all ones when vta_i = 1.
- R9: An element below vstart keeps its old value.
- R10: Results appear one cycle after valid_i, together with a one-cycle done_o. A legal operation sets the low destination-register-count bits of wr_reg_o and raises vstart_clr_o. An illegal operation leaves wr_reg_o at zero and vstart_clr_o low.
- R11: Bus registers beyond the destination group carry the old data unchanged.
- R12: After reset and in every cycle without done_o, illegal_o, wr_reg_o and vstart_clr_o are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation presented this cycle |
| funct6_i | input | 6 | funct6 field of the instruction |
| funct3_i | input | 3 | funct3 field of the instruction |
| sel_i | input | 5 | vs1 field, used as the even/odd selector |
| vm_i | input | 1 | 1 = unmasked, 0 = masked by mask register |
| vd_idx_i | input | 5 | Destination register number |
| vs2_idx_i | input | 5 | Source register number |
| sew_i | input | 3 | Element width code |
| lmul_i | input | 3 | Destination grouping code |
| vta_i | input | 1 | Tail policy, 1 = fill ones |
| vma_i | input | 1 | Inactive policy, 1 = fill ones |
| vl_i | input | VL_W | Vector length |
| vstart_i | input | VL_W | First element to process |
| v0_i | input | VLEN/2 | Mask bits indexed by destination element |
| src_i | input | 8*VLEN | Source group data |
| old_i | input | 4*VLEN | Old destination group data |
| done_o | output | 1 | Result valid pulse |
| illegal_o | output | 1 | Operation is illegal |
| wr_reg_o | output | 4 | Per-register write enable of the destination group |
| vstart_clr_o | output | 1 | Request to clear vstart |
| vd_data_o | output | 4*VLEN | Merged destination data |

## Verification
Sources filled with an element's own index show, at a glance, whether the even or the odd variant picked positions 2i or 2i+1. Random data then covers every element width and grouping, both selectors, random masks and random vl and vstart. Single-field edits around a legal operation check each illegal case against its legal neighbour: selector code, lmul 8 or reserved, misalignment, overlap, vl above VLMAX and masked writes to register 0. Fractional groupings and both policy bits, paired with vl and vstart at the edges, separate tail, inactive, prestart and out-of-group handling.

// File: rtl/vdeint_pkg.sv
package vdeint_pkg;
  localparam logic [5:0] F6_UNZIP = 6'b010010;
  localparam logic [2:0] F3_MVV   = 3'b010;

  typedef enum logic [4:0] {
    SEL_EVEN = 5'b01011,
    SEL_ODD  = 5'b01111
  } unzip_sel_e;

  localparam logic [2:0] LMUL_RSVD = 3'b100;
  localparam logic [2:0] LMUL_8    = 3'b011;
endpackage

// File: rtl/vdeint_decode.sv
module vdeint_decode
  import vdeint_pkg::*;
#(
  parameter int VLEN = 64,
  parameter int ELEN = 32,
  parameter int VL_W = 6
) (
  input  logic [5:0]      funct6_i,
  input  logic [2:0]      funct3_i,
  input  logic [4:0]      sel_i,
  input  logic            vm_i,
  input  logic [4:0]      vd_idx_i,
  input  logic [4:0]      vs2_idx_i,
  input  logic [2:0]      sew_i,
  input  logic [2:0]      lmul_i,
  input  logic [VL_W-1:0] vl_i,
  output logic            ill_o,
  output logic            odd_o,
  output logic [2:0]      nregd_o
);
  localparam int ELEN_LOG = $clog2(ELEN);

  always_comb begin
    int  lp, k, nd, ns, vmax, vd, vs;
    logic bad;
    lp = lmul_i[2] ? int'(lmul_i) - 8 : int'(lmul_i);
    k  = int'(sew_i);
    vd = int'(vd_idx_i);
    vs = int'(vs2_idx_i);
    odd_o = (sel_i == SEL_ODD);
    bad = !((funct6_i == F6_UNZIP) && (funct3_i == F3_MVV) &&
            ((sel_i == SEL_EVEN) || (sel_i == SEL_ODD)));
    if ((lmul_i == LMUL_RSVD) || (lmul_i == LMUL_8)) bad = 1'b1;
    if (k > ELEN_LOG - 3) bad = 1'b1;
    if (k + 3 > ELEN_LOG + lp) bad = 1'b1;
    nd   = (lp > 0) ? (1 << lp) : 1;
    ns   = (lp >= 0) ? (2 << lp) : 1;
    vmax = (lp >= 0) ? ((VLEN << lp) >> (k + 3)) : ((VLEN >> (-lp)) >> (k + 3));
    if (int'(vl_i) > vmax) bad = 1'b1;
    if (((vd & (nd - 1)) != 0) || ((vs & (ns - 1)) != 0)) bad = 1'b1;
    // overlap allowed only at the lowest-numbered source register
    if ((vd != vs) && (vd < vs + ns) && (vs < vd + nd)) bad = 1'b1;
    if (!vm_i && (vd == 0)) bad = 1'b1;
    ill_o   = bad;
    nregd_o = bad ? 3'd0 : 3'(nd);
  end
endmodule

// File: rtl/vdeint_lanes.sv
module vdeint_lanes #(
  parameter int VLEN = 64,
  parameter int ELEN = 32,
  parameter int VL_W = 6
) (
  input  logic                odd_i,
  input  logic                vm_i,
  input  logic                vta_i,
  input  logic                vma_i,
  input  logic [VL_W-1:0]     vl_i,
  input  logic [VL_W-1:0]     vstart_i,
  input  logic [2:0]          nregd_i,
  input  logic [2:0]          sew_i,
  input  logic [VLEN/2-1:0]   v0_i,
  input  logic [8*VLEN-1:0]   src_i,
  input  logic [4*VLEN-1:0]   old_i,
  output logic [4*VLEN-1:0]   res_o
);
  localparam int DW   = 4 * VLEN;
  localparam int NSEW = $clog2(ELEN) - 2;

  logic [NSEW-1:0][DW-1:0] res_all;

  for (genvar g = 0; g < NSEW; g++) begin : gen_sew
    localparam int EW = 8 << g;
    localparam int NE = DW / EW;
    logic [DW-1:0] res;

    always_comb begin
      int ge, vln, vst;
      ge  = int'(nregd_i) * (VLEN / EW);
      vln = int'(vl_i);
      vst = int'(vstart_i);
      res = old_i;
      for (int i = 0; i < NE; i++) begin
        if (i < ge && i >= vst) begin
          if (i >= vln) begin
            if (vta_i) res[i*EW +: EW] = '1;
          end else if (!vm_i && !v0_i[i]) begin
            if (vma_i) res[i*EW +: EW] = '1;
          end else begin
            res[i*EW +: EW] = odd_i ? src_i[(2*i+1)*EW +: EW] : src_i[(2*i)*EW +: EW];
          end
        end
      end
    end

    assign res_all[g] = res;
  end

  always_comb begin
    res_o = old_i;
    for (int g = 0; g < NSEW; g++) begin
      if (int'(sew_i) == g) res_o = res_all[g];
    end
  end
endmodule

// File: rtl/vdeint_unit.sv
module vdeint_unit #(
  parameter int VLEN = 64,
  parameter int ELEN = 32,
  parameter int VL_W = $clog2(VLEN / 2 + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [5:0]        funct6_i,
  input  logic [2:0]        funct3_i,
  input  logic [4:0]        sel_i,
  input  logic              vm_i,
  input  logic [4:0]        vd_idx_i,
  input  logic [4:0]        vs2_idx_i,
  input  logic [2:0]        sew_i,
  input  logic [2:0]        lmul_i,
  input  logic              vta_i,
  input  logic              vma_i,
  input  logic [VL_W-1:0]   vl_i,
  input  logic [VL_W-1:0]   vstart_i,
  input  logic [VLEN/2-1:0] v0_i,
  input  logic [8*VLEN-1:0] src_i,
  input  logic [4*VLEN-1:0] old_i,
  output logic              done_o,
  output logic              illegal_o,
  output logic [3:0]        wr_reg_o,
  output logic              vstart_clr_o,
  output logic [4*VLEN-1:0] vd_data_o
);
  localparam int NREG = 4;

  logic            ill, odd;
  logic [2:0]      nregd;
  logic [NREG-1:0] wmask;
  logic [4*VLEN-1:0] res;

  vdeint_decode #(.VLEN(VLEN), .ELEN(ELEN), .VL_W(VL_W)) u_dec (
    .funct6_i (funct6_i),
    .funct3_i (funct3_i),
    .sel_i    (sel_i),
    .vm_i     (vm_i),
    .vd_idx_i (vd_idx_i),
    .vs2_idx_i(vs2_idx_i),
    .sew_i    (sew_i),
    .lmul_i   (lmul_i),
    .vl_i     (vl_i),
    .ill_o    (ill),
    .odd_o    (odd),
    .nregd_o  (nregd)
  );

  vdeint_lanes #(.VLEN(VLEN), .ELEN(ELEN), .VL_W(VL_W)) u_lanes (
    .odd_i   (odd),
    .vm_i    (vm_i),
    .vta_i   (vta_i),
    .vma_i   (vma_i),
    .vl_i    (vl_i),
    .vstart_i(vstart_i),
    .nregd_i (nregd),
    .sew_i   (sew_i),
    .v0_i    (v0_i),
    .src_i   (src_i),
    .old_i   (old_i),
    .res_o   (res)
  );

  always_comb begin
    for (int r = 0; r < NREG; r++) wmask[r] = (r < int'(nregd));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o       <= 1'b0;
      illegal_o    <= 1'b0;
      wr_reg_o     <= '0;
      vstart_clr_o <= 1'b0;
      vd_data_o    <= '0;
    end else begin
      done_o       <= valid_i;
      illegal_o    <= valid_i && ill;
      wr_reg_o     <= (valid_i && !ill) ? wmask : '0;
      vstart_clr_o <= valid_i && !ill;
      if (valid_i) vd_data_o <= res;
    end
  end
endmodule

// File: rtl/vdeint_unit_chk.sv
module vdeint_unit_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic [4:0] sel_i,
  input logic [2:0] lmul_i,
  input logic       done_o,
  input logic       illegal_o,
  input logic [3:0] wr_reg_o,
  input logic       vstart_clr_o
);
  assert_done_follows_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);

  assert_done_only_after_valid_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);

  assert_illegal_no_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    illegal_o |-> (wr_reg_o == 4'b0) && !vstart_clr_o);

  assert_write_low_run_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !illegal_o) |-> (wr_reg_o != 4'b0) && ((wr_reg_o & (wr_reg_o + 4'd1)) == 4'b0));

  assert_lmul8_illegal_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && lmul_i == 3'b011) |=> illegal_o);

  assert_bad_sel_illegal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && sel_i != 5'b01011 && sel_i != 5'b01111) |=> illegal_o);

  assert_quiet_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !illegal_o && (wr_reg_o == 4'b0) && !vstart_clr_o);
endmodule

bind vdeint_unit vdeint_unit_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .valid_i     (valid_i),
  .sel_i       (sel_i),
  .lmul_i      (lmul_i),
  .done_o      (done_o),
  .illegal_o   (illegal_o),
  .wr_reg_o    (wr_reg_o),
  .vstart_clr_o(vstart_clr_o)
);

// File: tb/tb_vdeint_unit.sv
`timescale 1ns/1ps
module tb_vdeint_unit;
  localparam int VLEN = 64;
  localparam int DW   = 4 * VLEN;
  localparam int SW   = 8 * VLEN;
  localparam int VL_W = 6;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid = 1'b0;
  logic [5:0] f6 = 6'b010010;
  logic [2:0] f3 = 3'b010;
  logic [4:0] sel = 5'b01011;
  logic vm = 1'b1;
  logic [4:0] vd = 5'd8, vs2 = 5'd8;
  logic [2:0] sew = 3'd0, lmul = 3'd0;
  logic vta = 1'b0, vma = 1'b0;
  logic [VL_W-1:0] vl = '0, vst = '0;
  logic [VLEN/2-1:0] v0 = '0;
  logic [SW-1:0] src = '0;
  logic [DW-1:0] old = '0;

  logic done, ill, vclr;
  logic [3:0] wr;
  logic [DW-1:0] data;

  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  vdeint_unit #(.VLEN(VLEN), .ELEN(32)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .valid_i(valid),
    .funct6_i(f6), .funct3_i(f3), .sel_i(sel), .vm_i(vm),
    .vd_idx_i(vd), .vs2_idx_i(vs2), .sew_i(sew), .lmul_i(lmul),
    .vta_i(vta), .vma_i(vma), .vl_i(vl), .vstart_i(vst),
    .v0_i(v0), .src_i(src), .old_i(old),
    .done_o(done), .illegal_o(ill), .wr_reg_o(wr),
    .vstart_clr_o(vclr), .vd_data_o(data)
  );

  function automatic int lpow();
    return lmul[2] ? int'(lmul) - 8 : int'(lmul);
  endfunction

  function automatic int ndst();
    int lp = lpow();
    return (lp > 0) ? (1 << lp) : 1;
  endfunction

  function automatic bit exp_ill();
    int lp, k, nd, ns, vmax, a, b;
    if (!(f6 == 6'b010010 && f3 == 3'b010 && (sel == 5'b01011 || sel == 5'b01111))) return 1;
    if (lmul == 3'b100 || lmul == 3'b011 || sew > 3'd2) return 1;
    lp = lpow();
    k = int'(sew);
    if (lp < 0 && ((8 << k) << (-lp)) > 32) return 1;
    vmax = (lp >= 0) ? (VLEN << lp) / (8 << k) : (VLEN >> (-lp)) / (8 << k);
    if (int'(vl) > vmax) return 1;
    nd = ndst();
    ns = (lp >= 0) ? (2 << lp) : 1;
    a = int'(vd);
    b = int'(vs2);
    if ((a % nd) != 0 || (b % ns) != 0) return 1;
    if (a != b && a < b + ns && b < a + nd) return 1;
    if (!vm && a == 0) return 1;
    return 0;
  endfunction

  function automatic logic [DW-1:0] exp_data();
    logic [DW-1:0] r = old;
    int ew = 8 << int'(sew);
    int ge = ndst() * (VLEN / ew);
    int o = (sel == 5'b01111) ? 1 : 0;
    for (int i = 0; i < DW / ew; i++) begin
      for (int bt = 0; bt < ew; bt++) begin
        if (i >= ge || i < int'(vst)) r[i*ew+bt] = old[i*ew+bt];
        else if (i >= int'(vl)) r[i*ew+bt] = vta ? 1'b1 : old[i*ew+bt];
        else if (!vm && !v0[i]) r[i*ew+bt] = vma ? 1'b1 : old[i*ew+bt];
        else r[i*ew+bt] = src[(2*i+o)*ew+bt];
      end
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic fill_rand();
    for (int w = 0; w < SW / 32; w++) src[w*32 +: 32] = $urandom;
    for (int w = 0; w < DW / 32; w++) old[w*32 +: 32] = $urandom;
    v0 = $urandom;
  endtask

  task automatic run(input string req);
    bit ei;
    logic [3:0] ew;
    logic [DW-1:0] ed;
    @(negedge clk);
    valid = 1'b1;
    ei = exp_ill();
    ew = '0;
    if (!ei) for (int r = 0; r < ndst(); r++) ew[r] = 1'b1;
    ed = exp_data();
    @(negedge clk);
    valid = 1'b0;
    check(done == 1'b1, "R10", "done", DW'(done), DW'(1));
    check(ill == ei, req, "illegal", DW'(ill), DW'(ei));
    check(wr == ew, req, "wr_reg", DW'(wr), DW'(ew));
    check(vclr == !ei, "R10", "vstart_clr", DW'(vclr), DW'(!ei));
    if (!ei) check(data == ed, req, "data", data, ed);
  endtask

  task automatic base(input logic [2:0] s, input logic [2:0] l, input logic [4:0] sl);
    f6 = 6'b010010; f3 = 3'b010; sel = sl; vm = 1'b1;
    sew = s; lmul = l; vd = 5'd8; vs2 = 5'd8;
    vta = 1'b0; vma = 1'b0; vst = '0;
    vl = VL_W'((l[2] ? (VLEN >> (8 - int'(l))) : (VLEN << int'(l))) / (8 << int'(s)));
  endtask

  task automatic rand_legal();
    int k, lp, nd, ns;
    k = $urandom % 3;
    do lp = int'($urandom % 6) - 3; while (lp < 0 && ((8 << k) << (-lp)) > 32);
    sew = 3'(k);
    lmul = 3'(lp);
    sel = ($urandom % 2) ? 5'b01111 : 5'b01011;
    f6 = 6'b010010; f3 = 3'b010;
    nd = (lp > 0) ? (1 << lp) : 1;
    ns = (lp >= 0) ? (2 << lp) : 1;
    vs2 = 5'(($urandom % 32) & ~(ns - 1));
    if ($urandom % 2) vd = vs2;
    else begin
      do vd = 5'(($urandom % 32) & ~(nd - 1));
      while (!(int'(vd) + nd <= int'(vs2) || int'(vs2) + ns <= int'(vd)));
    end
    vm = $urandom % 2;
    if (!vm && vd == 5'd0) vm = 1'b1;
    vta = $urandom % 2; vma = $urandom % 2;
    begin
      int vmax = (lp >= 0) ? (VLEN << lp) / (8 << k) : (VLEN >> (-lp)) / (8 << k);
      vl = VL_W'($urandom % (vmax + 1));
      vst = VL_W'($urandom % (int'(vl) + 2));
    end
    fill_rand();
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    check(done == 0 && ill == 0 && wr == 0 && vclr == 0, "R12", "reset outputs",
          DW'({done, ill, wr, vclr}), DW'(0));
    rst_ni = 1'b1;
    @(negedge clk);
    check(done == 0 && wr == 0, "R12", "idle outputs", DW'({done, wr}), DW'(0));

    // R1 / R2 with index-valued bytes
    for (int j = 0; j < SW / 8; j++) src[j*8 +: 8] = 8'(j);
    old = '0;
    base(3'd0, 3'd0, 5'b01011); run("R1");
    check(data[8 +: 8] == 8'd2, "R1", "element 1 from source 2", DW'(data[8 +: 8]), DW'(2));
    base(3'd0, 3'd0, 5'b01111); run("R2");
    check(data[8 +: 8] == 8'd3, "R2", "element 1 from source 3", DW'(data[8 +: 8]), DW'(3));
    base(3'd0, 3'd2, 5'b01111); run("R2");
    check(data[31*8 +: 8] == 8'd63, "R2", "last element lmul4", DW'(data[31*8 +: 8]), DW'(63));

    // R3 selector and field decode
    fill_rand();
    base(3'd1, 3'd0, 5'b01010); run("R3");
    base(3'd1, 3'd0, 5'b01101); run("R3");
    base(3'd1, 3'd0, 5'b01011); f6 = 6'b010011; run("R3");
    base(3'd1, 3'd0, 5'b01011); f3 = 3'b000; run("R3");

    // R4 grouping / width legality
    base(3'd0, 3'd0, 5'b01011); lmul = 3'b011; run("R4");
    base(3'd0, 3'd0, 5'b01011); lmul = 3'b100; run("R4");
    base(3'd0, 3'd0, 5'b01011); sew = 3'd3; run("R4");
    base(3'd2, 3'b111, 5'b01011); vl = '0; run("R4");

    // R5 register rules
    base(3'd0, 3'd1, 5'b01011); vd = 5'd9; run("R5");
    base(3'd0, 3'd1, 5'b01011); vd = 5'd8; vs2 = 5'd10; vl = '0; vs2 = 5'd12; run("R5");
    base(3'd0, 3'd1, 5'b01011); vd = 5'd10; vs2 = 5'd8; run("R5");
    base(3'd0, 3'd0, 5'b01011); vd = 5'd4; vs2 = 5'd6; run("R5");
    base(3'd0, 3'd0, 5'b01011); vm = 1'b0; vd = 5'd0; vs2 = 5'd0; run("R5");

    // R6 vl above VLMAX
    base(3'd1, 3'd0, 5'b01011); vl = 6'd5; run("R6");

    // R7 inactive policy
    base(3'd0, 3'd0, 5'b01111); vm = 1'b0; v0 = 32'h0000_00A5; vma = 1'b0; run("R7");
    base(3'd0, 3'd0, 5'b01111); vm = 1'b0; v0 = 32'h0000_00A5; vma = 1'b1; run("R7");
    check(data[8 +: 8] == 8'hFF, "R7", "masked-off element ones", DW'(data[8 +: 8]), DW'(8'hFF));

    // R8 tail policy incl. fractional grouping
    base(3'd0, 3'b111, 5'b01011); vl = 6'd2; vta = 1'b1; run("R8");
    check(data[63:56] == 8'hFF, "R8", "tail in fractional register", DW'(data[63:56]), DW'(8'hFF));
    base(3'd0, 3'b111, 5'b01011); vl = 6'd2; vta = 1'b0; run("R8");
    check(data[63:56] == old[63:56], "R8", "tail kept", DW'(data[63:56]), DW'(old[63:56]));

    // R9 prestart
    base(3'd1, 3'd1, 5'b01011); vst = 6'd3; vta = 1'b1; run("R9");
    check(data[47:0] == old[47:0], "R9", "prestart kept", DW'(data[47:0]), DW'(old[47:0]));

    // R11 beyond group
    base(3'd2, 3'd0, 5'b01111); vta = 1'b1; run("R11");
    check(data[DW-1:VLEN] == old[DW-1:VLEN], "R11", "registers outside group",
          DW'(data[DW-1:VLEN]), DW'(old[DW-1:VLEN]));

    // random legal and random field mixes
    for (int n = 0; n < 400; n++) begin
      rand_legal();
      if (n % 8 == 7) begin
        lmul = 3'($urandom); sel = 5'($urandom); vd = 5'($urandom);
        run("R5");
      end else run(sel == 5'b01111 ? "R2" : "R1");
    end

    @(negedge clk);
    check(done == 0 && wr == 0 && vclr == 0, "R12", "quiet after ops",
          DW'({done, wr, vclr}), DW'(0));
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule